// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. Its job is to bring every target on the bus back to a known protocol state after a transfer was cut off or a system reset hit in the middle of a byte. A one-cycle trigger starts a fixed pattern on the bus. First comes a start condition. Then come nine clock pulses with the data line released, so that any target still shifting out a byte or waiting for an acknowledge clock can finish. A second start follows, and a stop ends the pattern. The bus is then held idle for the bus-free time, and the sequencer reports completion with a single-cycle pulse.

Both lines are open-drain. The block therefore drives two "pull low" enables and never a high level. A low enable means the line is released and floats high through the pull-up. Each phase length is a parameter given in system clock cycles. The integration sets these parameters to meet the bus minima for the chosen rate: low time, high time, start setup and hold, stop setup, and bus-free time. The block does not carry data and does not follow clock stretching.

Top module: `twowire_recover`

## Requirements
- R1: A synchronous active-high reset leaves both pull-low enables at 0 (lines released), `busy` at 0 and `done` at 0.
- R2: A `go` pulse seen while idle raises `busy` at the next clock edge. `busy` then stays high for exactly SETUP_CYC + HOLD_CYC + GAP_CYC + PULSES*(LOW_CYC+HIGH_CYC) + SETUP_CYC + HOLD_CYC + STOP_CYC + FREE_CYC cycles.
- R3: The first start keeps both lines released for SETUP_CYC cycles. It then pulls SDA low while SCL stays released, for HOLD_CYC cycles.
- R4: After the first start, SCL is pulled low with SDA still low for GAP_CYC cycles. The sequencer then gives PULSES clock pulses (default 9). Each pulse is LOW_CYC cycles with SCL low and SDA released, followed by HIGH_CYC cycles with both lines released.
- R5: SDA changes while SCL is released exactly three times per sequence: two falls (starts) and one rise (stop). All other SDA changes happen while SCL is low.
- R6: After the last high phase and a further SETUP_CYC cycles, SDA is pulled low with SCL released (second start). SDA stays low for HOLD_CYC + STOP_CYC cycles and is then released (stop). SCL does not go low between these two events.
- R7: After the stop, both lines stay released for FREE_CYC cycles while `busy` is still high. Whenever `busy` is low, both lines are released.
- R8: `done` is high for exactly one cycle, in the first cycle in which `busy` is low after a complete sequence.
- R9: A `go` pulse while `busy` is high has no effect. The pattern, its length and the single `done` pulse stay the same, and no new sequence starts afterwards.
- R10: A reset during a sequence stops it. After one edge both lines are released and `busy` and `done` are low.
- R11: SCL and SDA never change in the same clock cycle, except at a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a recovery sequence (sampled while idle) |
| scl_low | output | 1 | 1 pulls the SCL line low; 0 releases it |
| sda_low | output | 1 | 1 pulls the SDA line low; 0 releases it |
| busy | output | 1 | High from the edge after an accepted `go` until the bus-free time ends |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The properties assume `go` is a level sampled on the clock with no further protocol. They also assume reset comes only from the synchronous `rst` input, and that every phase-length parameter is at least 1. Because the block reads nothing back from the bus, the assertions need no assumption about other bus agents. The stimulus keeps to these rules. It gives `go` one-cycle pulses at random points: while idle, inside a sequence, and in the very last busy cycle. Between runs it leaves random idle gaps, and it places resets at random points inside a sequence, always held for a whole clock cycle.

// File: rtl/twowire_recover_pkg.sv
package twowire_recover_pkg;

    // Phases of the recovery pattern, in bus order.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SETUP1,   // both released, start setup
        PH_HOLD1,    // SDA low under high SCL: first start
        PH_FALL,     // SCL low, SDA still held low
        PH_LOW,      // dummy clock low, SDA released
        PH_HIGH,     // dummy clock high, SDA released
        PH_SETUP2,   // both released, second start setup
        PH_HOLD2,    // SDA low under high SCL: second start
        PH_STOPSU,   // SDA still low, stop setup
        PH_FREE      // both released, bus-free time
    } phase_t;

    // Open-drain pull-low enables for the two lines.
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } drive_t;

    function automatic drive_t drive_of(phase_t p);
        drive_t d;
        case (p)
            PH_HOLD1, PH_HOLD2, PH_STOPSU: d = '{scl_low: 1'b0, sda_low: 1'b1};
            PH_FALL:                       d = '{scl_low: 1'b1, sda_low: 1'b1};
            PH_LOW:                        d = '{scl_low: 1'b1, sda_low: 1'b0};
            default:                       d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/twowire_recover_timer.sv
module twowire_recover_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/twowire_recover_seq.sv
module twowire_recover_seq
    import twowire_recover_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 120,
    parameter int unsigned HOLD_CYC  = 120,
    parameter int unsigned GAP_CYC   = 20,
    parameter int unsigned LOW_CYC   = 260,
    parameter int unsigned HIGH_CYC  = 120,
    parameter int unsigned STOP_CYC  = 120,
    parameter int unsigned FREE_CYC  = 260,
    parameter int unsigned PULSES    = 9,
    parameter int unsigned CNT_W     = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             zero,
    output phase_t           ph,
    output phase_t           ph_nxt,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             done
);
    localparam int unsigned PC_W = $clog2(PULSES + 1);
    localparam logic [PC_W-1:0] LAST_PULSE = PC_W'(PULSES - 1);

    logic [PC_W-1:0] pulse_cnt;

    function automatic logic [CNT_W-1:0] len_of(phase_t p);
        case (p)
            PH_SETUP1, PH_SETUP2: return CNT_W'(SETUP_CYC - 1);
            PH_HOLD1,  PH_HOLD2:  return CNT_W'(HOLD_CYC - 1);
            PH_FALL:              return CNT_W'(GAP_CYC - 1);
            PH_LOW:               return CNT_W'(LOW_CYC - 1);
            PH_HIGH:              return CNT_W'(HIGH_CYC - 1);
            PH_STOPSU:            return CNT_W'(STOP_CYC - 1);
            PH_FREE:              return CNT_W'(FREE_CYC - 1);
            default:              return '0;
        endcase
    endfunction

    always_comb begin
        ph_nxt = ph;
        if (ph == PH_IDLE) begin
            if (go) ph_nxt = PH_SETUP1;
        end else if (zero) begin
            case (ph)
                PH_SETUP1: ph_nxt = PH_HOLD1;
                PH_HOLD1:  ph_nxt = PH_FALL;
                PH_FALL:   ph_nxt = PH_LOW;
                PH_LOW:    ph_nxt = PH_HIGH;
                PH_HIGH:   ph_nxt = (pulse_cnt == LAST_PULSE) ? PH_SETUP2 : PH_LOW;
                PH_SETUP2: ph_nxt = PH_HOLD2;
                PH_HOLD2:  ph_nxt = PH_STOPSU;
                PH_STOPSU: ph_nxt = PH_FREE;
                default:   ph_nxt = PH_IDLE;
            endcase
        end
        load     = (ph_nxt != ph);
        load_val = len_of(ph_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            pulse_cnt <= '0;
            done      <= 1'b0;
        end else begin
            ph   <= ph_nxt;
            done <= (ph == PH_FREE) && zero;
            if (ph == PH_IDLE) begin
                pulse_cnt <= '0;
            end else if (ph == PH_HIGH && zero) begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/twowire_recover_drive.sv
module twowire_recover_drive
    import twowire_recover_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph_nxt,
    output drive_t drv
);
    // Registered so the open-drain enables switch cleanly on a clock edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            drv <= '{scl_low: 1'b0, sda_low: 1'b0};
        end else begin
            drv <= drive_of(ph_nxt);
        end
    end
endmodule

// File: rtl/twowire_recover.sv
module twowire_recover
    import twowire_recover_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 120,
    parameter int unsigned HOLD_CYC  = 120,
    parameter int unsigned GAP_CYC   = 20,
    parameter int unsigned LOW_CYC   = 260,
    parameter int unsigned HIGH_CYC  = 120,
    parameter int unsigned STOP_CYC  = 120,
    parameter int unsigned FREE_CYC  = 260,
    parameter int unsigned PULSES    = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic scl_low,
    output logic sda_low,
    output logic busy,
    output logic done
);
    localparam int unsigned MAX_LEN =
        max_of(max_of(max_of(SETUP_CYC, HOLD_CYC), max_of(GAP_CYC, LOW_CYC)),
               max_of(max_of(HIGH_CYC, STOP_CYC), FREE_CYC));
    localparam int unsigned CNT_W = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    phase_t           ph;
    phase_t           ph_nxt;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             zero;
    drive_t           drv;

    twowire_recover_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .zero     (zero)
    );

    twowire_recover_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .GAP_CYC   (GAP_CYC),
        .LOW_CYC   (LOW_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .STOP_CYC  (STOP_CYC),
        .FREE_CYC  (FREE_CYC),
        .PULSES    (PULSES),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .zero     (zero),
        .ph       (ph),
        .ph_nxt   (ph_nxt),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    twowire_recover_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .ph_nxt (ph_nxt),
        .drv    (drv)
    );

    assign scl_low = drv.scl_low;
    assign sda_low = drv.sda_low;
    assign busy    = (ph != PH_IDLE);
endmodule

// File: rtl/twowire_recover_chk.sv
module twowire_recover_chk #(
    parameter int unsigned PULSES = 9
) (
    input logic clk,
    input logic rst,
    input logic go,
    input logic scl_low,
    input logic sda_low,
    input logic busy,
    input logic done
);
    localparam int unsigned FW = $clog2(PULSES + 2);

    logic [FW-1:0] falls;
    logic          scl_q;

    // Counts SCL falls within one sequence.
    always_ff @(posedge clk) begin
        if (rst) begin
            falls <= '0;
            scl_q <= 1'b0;
        end else begin
            scl_q <= scl_low;
            if (!busy) falls <= '0;
            else if (scl_low && !scl_q) falls <= falls + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!scl_low && !sda_low && !busy && !done));

    p_go_starts_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && go) |=> busy);

    p_falls_max_r4: assert property (@(posedge clk) disable iff (rst)
        falls <= FW'(PULSES));

    p_release_in_high_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !scl_low && falls >= FW'(1) && falls < FW'(PULSES)) |-> !sda_low);

    p_start_window_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $rose(sda_low) && !scl_low) |-> (falls == '0 || falls == FW'(PULSES)));

    p_idle_released_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_low && !sda_low));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_one_line_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !(!$stable(scl_low) && !$stable(sda_low)));
endmodule

bind twowire_recover twowire_recover_chk #(.PULSES(PULSES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .scl_low (scl_low),
    .sda_low (sda_low),
    .busy    (busy),
    .done    (done)
);

// File: tb/twowire_recover_test.sv
`timescale 1ns/1ps
module twowire_recover_test;
    localparam int SU  = 5;
    localparam int HD  = 6;
    localparam int GP  = 2;
    localparam int LO  = 9;
    localparam int HI  = 4;
    localparam int STO = 7;
    localparam int BF  = 11;
    localparam int NP  = 9;
    localparam int NSEG = 2 * NP + 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go  = 1'b0;
    logic scl_low, sda_low, busy, done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    twowire_recover #(
        .SETUP_CYC(SU), .HOLD_CYC(HD), .GAP_CYC(GP), .LOW_CYC(LO),
        .HIGH_CYC(HI), .STOP_CYC(STO), .FREE_CYC(BF), .PULSES(NP)
    ) uut (
        .clk(clk), .rst(rst), .go(go),
        .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .done(done)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected line pattern as run-length segments (line levels, 1 = high).
    function automatic int exp_len(int i);
        if (i == 0) return SU;
        if (i == 1) return HD;
        if (i == 2) return GP;
        if (i < 2 * NP + 3) begin
            if ((i % 2) == 1) return LO;
            return (i == 2 * NP + 2) ? HI + SU : HI;
        end
        if (i == 2 * NP + 3) return HD + STO;
        return BF;
    endfunction

    function automatic bit exp_scl(int i);
        if (i == 2) return 1'b0;
        if (i >= 3 && i < 2 * NP + 3) return (i % 2) == 0;
        return 1'b1;
    endfunction

    function automatic bit exp_sda(int i);
        if (i == 1 || i == 2 || i == 2 * NP + 3) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_total();
        return SU + HD + GP + NP * (LO + HI) + SU + HD + STO + BF;
    endfunction

    function automatic string req_of(int i);
        if (i < 2) return "R3";
        if (i < 2 * NP + 3) return "R4";
        if (i == 2 * NP + 3) return "R6";
        return "R7";
    endfunction

    // One full sequence; inject_at > 0 pulses go at that busy cycle (R9).
    task automatic run_seq(int inject_at);
        int seg_len[64];
        bit seg_scl[64];
        bit seg_sda[64];
        int nseg = 0, n = 0, starts = 0, stops = 0, rises = 0, both = 0;
        bit p_scl = 1'b1, p_sda = 1'b1;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        chk(busy == 1'b1, "R2", "busy after go", int'(busy), 1);
        while (busy && n < 4 * exp_total()) begin
            bit c_scl = !scl_low;
            bit c_sda = !sda_low;
            if (p_scl && c_scl && p_sda && !c_sda) starts++;
            if (p_scl && c_scl && !p_sda && c_sda) stops++;
            if (!p_scl && c_scl) rises++;
            if (p_scl != c_scl && p_sda != c_sda) both++;
            if (nseg > 0 && seg_scl[nseg-1] == c_scl && seg_sda[nseg-1] == c_sda) begin
                seg_len[nseg-1]++;
            end else if (nseg < 64) begin
                seg_scl[nseg] = c_scl; seg_sda[nseg] = c_sda; seg_len[nseg] = 1;
                nseg++;
            end
            p_scl = c_scl; p_sda = c_sda;
            n++;
            go = (n == inject_at);
            @(negedge clk);
        end
        go = 1'b0;
        chk(n == exp_total(), "R2", "busy length", n, exp_total());
        chk(done == 1'b1, "R8", "done at end", int'(done), 1);
        chk(nseg == NSEG, "R4", "segment count", nseg, NSEG);
        for (int i = 0; i < NSEG && i < nseg; i++) begin
            chk(seg_scl[i] == exp_scl(i) && seg_sda[i] == exp_sda(i), req_of(i),
                $sformatf("segment %0d levels", i), {seg_scl[i], seg_sda[i]},
                {exp_scl(i), exp_sda(i)});
            chk(seg_len[i] == exp_len(i), req_of(i), $sformatf("segment %0d length", i),
                seg_len[i], exp_len(i));
        end
        chk(starts == 2, "R5", "start count", starts, 2);
        chk(stops == 1, "R6", "stop count", stops, 1);
        chk(rises == NP, "R4", "SCL rises", rises, NP);
        chk(both == 0, "R11", "both lines changed together", both, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single cycle", int'(done), 0);
        chk(busy == 1'b0, "R9", "no restart after sequence", int'(busy), 0);
        chk(!scl_low && !sda_low, "R7", "lines released when idle",
            {scl_low, sda_low}, 0);
    endtask

    // Reset inside a sequence (R10).
    task automatic run_abort(int at);
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        repeat (at) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!scl_low && !sda_low, "R10", "lines released after reset",
            {scl_low, sda_low}, 0);
        chk(!busy && !done, "R10", "busy/done low after reset", {busy, done}, 0);
        @(negedge clk);
        chk(!busy, "R10", "stays idle after reset", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: actual hung expected sequence end");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(scl_low == 1'b0, "R1", "scl_low in reset", int'(scl_low), 0);
        chk(sda_low == 1'b0, "R1", "sda_low in reset", int'(sda_low), 0);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corners
        run_seq(0);
        run_seq(1);               // R9: go in first busy cycle
        run_seq(exp_total());     // R9: go in last busy cycle
        run_abort(SU + HD + 1);   // R10: reset while SCL and SDA both low
        run_seq(0);

        // Random mix
        for (int k = 0; k < 10; k++) begin
            repeat ($urandom % 7) @(negedge clk);
            r = $urandom % 3;
            if (r == 0) run_seq(0);
            else if (r == 1) run_seq(1 + ($urandom % exp_total()));
            else run_abort($urandom % (exp_total() - 2));
        end
        run_seq(0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule